// File: doc/BRIEF.md
# Port-Triggered SPI Master Shifter

This block is an SPI master attached to the I/O port bus of a small 8-bit processor. A qualified write to one data port puts the byte into a transmit shift register. That same write starts a fixed burst of eight serial clock pulses. There is no separate start command. While the burst runs, the byte leaves MSB first on MOSI. Bits arriving on MISO shift into a receive register, which is copied into a storage register on every falling serial clock edge. The processor reads the storage register back through the input side of the same port.

The serial clock is divided down from the system clock by a counter. Each half period lasts `HALF_DIV` system clocks, so the default of 25 gives 1 MHz from a 50 MHz clock. The load strobe must also see the bus's late-cycle timing pulse with the memory-read line inactive. Because of that qualification, software can issue port accesses back to back without padding between them. The serial clock idles low (mode 0), and a complementary clock is driven alongside it.

Top module: `spi_port_master`

## Requirements
- R1: A write (`bus_wr`=1) to port `PORT_ID` (default 6) with `late_strobe`=1 and `mem_read_n`=1 while idle loads `bus_wdata` on that clock edge, and `xfer_busy` is 1 from the next cycle.
- R2: A write to any other port, or one with `late_strobe`=0, or one with `mem_read_n`=0, starts nothing: `xfer_busy` and `sck` stay 0.
- R3: `sck` idles low. Each transfer gives exactly 8 high pulses, each half period lasting `HALF_DIV` clocks. `xfer_busy` falls on the 8th falling edge, 16*`HALF_DIV` clock edges after the loading edge.
- R4: `sck_n` is always the complement of `sck`.
- R5: MOSI carries the loaded byte MSB first. The first bit is present from the load, and MOSI changes only on falling `sck` edges.
- R6: MISO is sampled on each rising `sck` edge, MSB first, into the receive shift register.
- R7: The storage register takes the receive shift register on each falling `sck` edge. After a transfer it holds the full byte received.
- R8: `bus_rdata` shows the storage register when `bus_rd`=1 and `bus_port`=`PORT_ID`, and shows 0 otherwise.
- R9: A qualified write while `xfer_busy`=1 is ignored. MOSI keeps sending the original byte, and the burst ends at its original time.
- R10: While idle, repeated reads return the last received byte unchanged.
- R11: After reset: `xfer_busy`=0, `sck`=0, `sck_n`=1, `mosi`=0, and the storage register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_port | input | PORT_W | I/O port number of the current access |
| bus_wdata | input | 8 | Byte written by the processor |
| bus_wr | input | 1 | Output-port write strobe |
| bus_rd | input | 1 | Input-port read strobe |
| late_strobe | input | 1 | Late-cycle bus timing pulse |
| mem_read_n | input | 1 | Memory read line, active low |
| miso | input | 1 | Serial data from the slave |
| bus_rdata | output | 8 | Read data for the input port |
| xfer_busy | output | 1 | Burst in progress |
| sck | output | 1 | Serial clock |
| sck_n | output | 1 | Inverted serial clock |
| mosi | output | 1 | Serial data to the slave |

## Verification
The bench builds the block with `HALF_DIV`=3 instead of 25. A full burst then takes 48 cycles, so many byte patterns fit in a short run. An odd divider also makes sure the half-period count is not hidden by a divide-by-two. `PORT_ID` stays at 6, and the port-mismatch cases use 5 and 7, the neighbouring addresses. A write injected in the middle of a burst shows that busy-time writes are ignored, because the original byte still appears bit for bit on MOSI.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned BURST_BITS = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;

  function automatic int unsigned burst_cycles(int unsigned half_div);
    return 2 * BURST_BITS * half_div;
  endfunction

  function automatic logic port_match(logic [7:0] port, logic [7:0] id);
    return port == id;
  endfunction
endpackage

// File: rtl/spi_port_decode.sv
module spi_port_decode #(
  parameter int unsigned PORT_W  = 3,
  parameter int unsigned PORT_ID = 6
) (
  input  logic [PORT_W-1:0] bus_port,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              late_strobe,
  input  logic              mem_read_n,
  output logic              load_req,
  output logic              rd_hit
);
  import spi_port_pkg::*;
  logic sel;
  assign sel      = port_match(8'(bus_port), 8'(PORT_ID));
  assign load_req = bus_wr & late_strobe & mem_read_n & sel;
  assign rd_hit   = bus_rd & sel;
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq #(
  parameter int unsigned HALF_DIV = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_req,
  output logic                  load_go,
  output logic                  busy,
  output logic                  sck,
  output logic                  sck_n,
  output spi_port_pkg::sck_evt_t evt
);
  import spi_port_pkg::*;
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(BURST_BITS + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             tick;
  logic             last_fall;

  always_comb begin
    tick      = busy && (div_cnt == DIV_W'(HALF_DIV - 1));
    evt.rise  = tick & ~sck;
    evt.fall  = tick & sck;
    last_fall = evt.fall && (bit_cnt == BIT_W'(BURST_BITS - 1));
    load_go   = load_req & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (load_go) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (evt.rise) sck <= 1'b1;
      if (evt.fall) begin
        sck     <= 1'b0;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (last_fall) busy <= 1'b0;
    end
  end

  assign sck_n = ~sck;

  // R3: serial clock low whenever no burst runs
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R3: a burst ends on a falling serial clock edge
  a_r3_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(sck));
  // R1: an accepted load makes the block busy
  a_r1_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> busy);
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_go,
  input  logic [7:0]             tx_byte,
  input  spi_port_pkg::sck_evt_t evt,
  input  logic                   miso,
  output logic                   mosi,
  output logic [7:0]             hold
);
  import spi_port_pkg::*;
  logic [BURST_BITS-1:0] tx_sh;
  logic [BURST_BITS-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      hold  <= '0;
    end else begin
      if (load_go)       tx_sh <= tx_byte;
      else if (evt.fall) tx_sh <= {tx_sh[BURST_BITS-2:0], 1'b0};
      if (evt.rise)      rx_sh <= {rx_sh[BURST_BITS-2:0], miso};
      if (evt.fall)      hold  <= rx_sh;
    end
  end

  assign mosi = tx_sh[BURST_BITS-1];

  // R5: data out does not move on a rising serial clock edge
  a_r5_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> $stable(mosi));
endmodule

// File: rtl/spi_port_master.sv
module spi_port_master #(
  parameter int unsigned PORT_W   = 3,
  parameter int unsigned PORT_ID  = 6,
  parameter int unsigned HALF_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] bus_port,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              late_strobe,
  input  logic              mem_read_n,
  input  logic              miso,
  output logic [7:0]        bus_rdata,
  output logic              xfer_busy,
  output logic              sck,
  output logic              sck_n,
  output logic              mosi
);
  import spi_port_pkg::*;

  logic     load_req;
  logic     rd_hit;
  logic     load_go;
  sck_evt_t evt;
  logic [7:0] hold;

  spi_port_decode #(.PORT_W(PORT_W), .PORT_ID(PORT_ID)) u_decode (
    .bus_port(bus_port), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .late_strobe(late_strobe), .mem_read_n(mem_read_n),
    .load_req(load_req), .rd_hit(rd_hit)
  );

  spi_burst_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_go(load_go),
    .busy(xfer_busy), .sck(sck), .sck_n(sck_n), .evt(evt)
  );

  spi_shift_path u_path (
    .clk(clk), .rst_n(rst_n), .load_go(load_go), .tx_byte(bus_wdata),
    .evt(evt), .miso(miso), .mosi(mosi), .hold(hold)
  );

  assign bus_rdata = rd_hit ? hold : 8'h00;

  // R10: storage register does not change while idle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && $past(!xfer_busy)) |-> $stable(hold));
  // R9: a write during a burst does not disturb the bit on the wire
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && load_req && !evt.fall) |=> $stable(mosi));
endmodule

// File: tb/spi_port_master_bench.sv
module spi_port_master_bench;
  localparam int unsigned HALF = 3;
  localparam int unsigned BURST = 16 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_port = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic bus_wr = 1'b0, bus_rd = 1'b0, late_strobe = 1'b0, mem_read_n = 1'b1;
  logic miso;
  logic [7:0] bus_rdata;
  logic xfer_busy, sck, sck_n, mosi;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spi_port_master #(.PORT_W(3), .PORT_ID(6), .HALF_DIV(HALF)) u_spi_port_master (
    .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .late_strobe(late_strobe),
    .mem_read_n(mem_read_n), .miso(miso), .bus_rdata(bus_rdata),
    .xfer_busy(xfer_busy), .sck(sck), .sck_n(sck_n), .mosi(mosi)
  );

  // slave model: shifts out on falling sck, records mosi on rising sck
  logic [7:0] slave_seed = 8'h00;
  logic [7:0] slv = 8'h00;
  logic [7:0] mosi_got = 8'h00;
  logic prev_sck = 1'b0;
  int rises = 0;
  int r4_bad = 0;
  initial miso = 1'b0;
  always @(negedge clk) begin
    if (sck_n !== ~sck) r4_bad++;
    if (!prev_sck && sck) begin
      mosi_got = {mosi_got[6:0], mosi};
      rises++;
    end else if (prev_sck && !sck) begin
      slv = {slv[6:0], 1'b0};
    end else if (!xfer_busy && !sck) begin
      slv = slave_seed;
    end
    miso = slv[7];
    prev_sck = sck;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_port(input logic [2:0] p, output logic [7:0] d);
    bus_port = p; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0; bus_port = 3'd0;
  endtask

  // one full transfer; optional write injected mid-burst
  task automatic burst(logic [7:0] tx, logic [7:0] sv, bit inject, string tag);
    int cnt;
    int base;
    logic [7:0] rd;
    slave_seed = sv;
    @(negedge clk);
    base = rises;
    bus_port = 3'd6; bus_wdata = tx; bus_wr = 1'b1;
    late_strobe = 1'b1; mem_read_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; late_strobe = 1'b0; bus_wdata = 8'h00;
    check({tag, " R1 busy after load"}, xfer_busy, 1);
    cnt = 0;
    while (xfer_busy && cnt < BURST + 10) begin
      if (inject && cnt == 2 * HALF + 1) begin
        bus_wdata = ~tx; bus_wr = 1'b1; late_strobe = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; late_strobe = 1'b0;
      cnt++;
    end
    check({tag, " R3 burst length"}, cnt, BURST);
    check({tag, " R3 pulse count"}, rises - base, 8);
    check({tag, " R5 mosi byte"}, mosi_got, tx);
    read_port(3'd6, rd);
    check({tag, " R6 R7 received byte"}, rd, sv);
  endtask

  localparam logic [15:0] VEC [6] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h80_01, 16'h01_80, 16'h5A_C3
  };

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R11 busy reset", xfer_busy, 0);
    check("R11 sck reset", sck, 0);
    check("R11 sck_n reset", sck_n, 1);
    check("R11 mosi reset", mosi, 0);
    read_port(3'd6, rd);
    check("R11 storage reset", rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) burst(VEC[i][15:8], VEC[i][7:0], 1'b0, "vec");

    // R2: unqualified writes start nothing
    bus_wdata = 8'hAA; bus_wr = 1'b1;
    bus_port = 3'd5; late_strobe = 1'b1; mem_read_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 other port 5", xfer_busy, 0);
    bus_port = 3'd7;
    @(posedge clk); @(negedge clk);
    check("R2 other port 7", xfer_busy, 0);
    bus_port = 3'd6; late_strobe = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 no late strobe", xfer_busy, 0);
    late_strobe = 1'b1; mem_read_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 memory read active", xfer_busy, 0);
    check("R2 sck idle", sck, 0);
    bus_wr = 1'b0; late_strobe = 1'b0; mem_read_n = 1'b1; bus_port = 3'd0;
    repeat (2 * HALF) @(negedge clk);
    check("R2 sck still idle", sck, 0);

    // R10: idle reads return last byte unchanged
    read_port(3'd6, rd);
    check("R10 first idle read", rd, 8'hC3);
    repeat (5) @(negedge clk);
    read_port(3'd6, rd);
    check("R10 second idle read", rd, 8'hC3);

    // R8: read of other port or without strobe gives 0
    read_port(3'd4, rd);
    check("R8 other port read", rd, 0);
    bus_port = 3'd6;
    #1 check("R8 no read strobe", bus_rdata, 0);
    bus_port = 3'd0;

    // R9: write while busy ignored
    burst(8'hC6, 8'h69, 1'b1, "R9");

    check("R4 sck_n complement mismatches", r4_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule